// File: doc/BRIEF.md
# ADC Conversion Trigger and Sequencing Controller

This block runs the digital side of a 12-bit successive-approximation converter. A small configuration word chooses the start source, whether conversions repeat, how long the input is sampled and how the result is laid out in a 16-bit word. Software first arms the block. It then waits for the chosen start event, counts a sampling window in pulses of a sampling clock enable, and raises a one-cycle convert request to the converter. When the converter returns its done strobe, the block captures the 12-bit value.

The captured value is presented as a 16-bit word. The alignment bit shapes that word only at the output, so the layout can change at any moment without touching the stored value. A busy flag covers the whole period from start acceptance until the block falls idle. A stop pulse ends a repeating run once the conversion already in flight has been captured. A ready pulse marks each new value, and an overrun flag reports any value that was replaced before it was read. A 2-bit voltage-range field sits beside the configuration and takes writes only while the block is not busy.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the configuration word is 0, so the block uses right alignment, single mode, software start and a 4-pulse window. `busy`, `conv_req`, `res_ready`, `overrun`, `vrange` and `result` are all 0.
- R2: `result` is `{data,4'b0}` when the configuration bit 0 (align) is 1 and `{4'b0,data}` when it is 0. A new align value shows on `result` from the cycle after the write, and the stored 12-bit value does not change.
- R3: Configuration bits 3:2 pick the start source while the block is armed. Code 0 is a `sw_start` pulse, code 2 is a `tmr_uf` pulse and code 3 is a falling edge on `ext_trig_n`. Code 1 never starts a conversion.
- R4: Configuration bits 6:4 hold a code N. After start acceptance, `conv_req` rises in the cycle that follows the (N+4)-th `smp_ce` pulse seen while sampling.
- R5: When configuration bit 1 (repeat) is 0, the block goes idle after one capture, and a new `arm` is needed before the next start.
- R6: When configuration bit 1 is 1, the block returns to sampling after each capture without a new start event. A `sw_stop` pulse while busy makes it go idle after the next capture. A `sw_stop` pulse while armed and not busy disarms the block.
- R7: `ext_trig_n` passes through two synchronizing flops. A falling edge applied just before edge k is accepted at edge k+2, so `busy` is 1 from edge k+2. Holding the pin low produces no further starts.
- R8: `busy` is 1 from the edge that accepts the start until the edge that returns the block to idle. It is 0 while idle or merely armed.
- R9: A `vr_wr` write updates `vrange` only if `busy` is 0 in the write cycle. Otherwise the write is ignored.
- R10: `res_ready` is a one-cycle pulse, and `result` carries the new value in that same cycle. The pulse starts the cycle after `conv_done` is accepted.
- R11: `overrun` is set when a capture happens while the previous value is still unread. A `res_read` pulse clears it and marks the value as read.
- R12: `conv_req` lasts exactly one cycle. A `conv_done` pulse during that request cycle, or while the block is idle, armed or sampling, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration: [0] align, [1] repeat, [3:2] start source, [6:4] window code |
| vr_wr | input | 1 | Voltage-range write strobe |
| vr_wdata | input | 2 | Voltage-range value |
| arm | input | 1 | Arm pulse: idle to waiting for start |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Stop pulse |
| tmr_uf | input | 1 | Timer underflow pulse |
| ext_trig_n | input | 1 | Asynchronous active-low external start pin |
| smp_ce | input | 1 | Sampling clock enable |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter result |
| res_read | input | 1 | Result read pulse |
| conv_req | output | 1 | One-cycle convert request |
| busy | output | 1 | Conversion activity flag |
| result | output | 16 | Aligned result word |
| res_ready | output | 1 | New-result pulse |
| overrun | output | 1 | Unread result was overwritten |
| vrange | output | 2 | Voltage-range field |

## Verification
A start event or a window-completing `smp_ce` pulse is visible on `busy` or `conv_req` one cycle later. An external pin fall is visible three edges after the pin changes. A `conv_done` accepted at an edge shows on `res_ready`, `overrun` and `result` right after that edge, and an align or voltage-range write shows on the next cycle. The bench keeps a behavioural model that is advanced at each rising edge from the inputs held across it, and compares every output to the model at each falling edge. Directed checks at those same falling edges add the start-source, synchronizer-latency and end-of-run cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 16;
    localparam int WCODE_W  = 3;
    localparam int WIN_BASE = 4;
    localparam int PAD_W    = WORD_W - SAMPLE_W;
    localparam int WCNT_W   = $clog2((1 << WCODE_W) + WIN_BASE);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_SAMP  = 3'd2,
        ST_CONV  = 3'd3,
        ST_CAPT  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_NONE  = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_PIN   = 2'd3
    } start_src_t;

    typedef struct packed {
        logic [WCODE_W-1:0] wcode;
        start_src_t         src;
        logic               repeat_en;
        logic               align_left;
    } seq_cfg_t;

    function automatic logic [WCNT_W-1:0] window_len(input logic [WCODE_W-1:0] code);
        return WCNT_W'(code) + WCNT_W'(WIN_BASE);
    endfunction

    function automatic logic [WORD_W-1:0] shape_word(input logic [SAMPLE_W-1:0] d,
                                                     input logic left);
        return left ? {d, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, d};
    endfunction
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  start_src_t src,
    input  logic       sw_start,
    input  logic       tmr_uf,
    input  logic       ext_trig_n,
    output logic       fire
);
    logic [2:0] pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 3'b111;
        else     pin_q <= {pin_q[1:0], ext_trig_n};
    end

    logic pin_fall;
    assign pin_fall = pin_q[2] & ~pin_q[1];

    always_comb begin
        unique case (src)
            SRC_SOFT:  fire = sw_start;
            SRC_TIMER: fire = tmr_uf;
            SRC_PIN:   fire = pin_fall;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               fire,
    input  logic               sw_stop,
    input  logic               smp_ce,
    input  logic               repeat_en,
    input  logic [WCODE_W-1:0] wcode,
    input  logic               conv_done,
    output logic               conv_req,
    output logic               busy,
    output logic               capture
);
    seq_state_t        state_q, state_d;
    logic [WCNT_W-1:0] cnt_q, cnt_d;
    logic              stop_q, stop_d;

    assign busy     = (state_q == ST_SAMP) || (state_q == ST_CONV) || (state_q == ST_CAPT);
    assign conv_req = (state_q == ST_CONV);
    assign capture  = (state_q == ST_CAPT) && conv_done;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (sw_stop) state_d = ST_IDLE;
                else if (fire) begin
                    state_d = ST_SAMP;
                    cnt_d   = '0;
                end
            end
            ST_SAMP: begin
                if (smp_ce) begin
                    if (cnt_q == window_len(wcode) - 1'b1) state_d = ST_CONV;
                    else cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CONV:  state_d = ST_CAPT;
            ST_CAPT: begin
                if (conv_done) begin
                    if (repeat_en && !stop_q && !sw_stop) begin
                        state_d = ST_SAMP;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default:  state_d = ST_IDLE;
        endcase
        if (state_d == ST_IDLE)      stop_d = 1'b0;
        else if (sw_stop && busy)    stop_d = 1'b1;
        else                         stop_d = stop_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            stop_q  <= stop_d;
        end
    end

    assert_req_single_R12: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);
    assert_req_after_ce_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req) |-> $past(smp_ce));
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic                align_left,
    input  logic                res_read,
    output logic [WORD_W-1:0]   result,
    output logic                res_ready,
    output logic                overrun
);
    logic [SAMPLE_W-1:0] data_q;
    logic                unread_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            unread_q  <= 1'b0;
            res_ready <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            res_ready <= capture;
            if (capture) data_q <= conv_data;
            if (capture)       unread_q <= 1'b1;
            else if (res_read) unread_q <= 1'b0;
            if (capture && unread_q && !res_read) overrun <= 1'b1;
            else if (res_read)                    overrun <= 1'b0;
        end
    end

    assign result = shape_word(data_q, align_left);

    assert_ready_single_R10: assert property (@(posedge clk) disable iff (rst)
        res_ready |=> !res_ready);
    assert_ovr_with_ready_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> res_ready);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [6:0]          cfg_wdata,
    input  logic                vr_wr,
    input  logic [1:0]          vr_wdata,
    input  logic                arm,
    input  logic                sw_start,
    input  logic                sw_stop,
    input  logic                tmr_uf,
    input  logic                ext_trig_n,
    input  logic                smp_ce,
    input  logic                conv_done,
    input  logic [11:0]         conv_data,
    input  logic                res_read,
    output logic                conv_req,
    output logic                busy,
    output logic [15:0]         result,
    output logic                res_ready,
    output logic                overrun,
    output logic [1:0]          vrange
);
    seq_cfg_t cfg_q;
    logic     fire, capture;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            vrange <= '0;
        end else begin
            if (cfg_wr)          cfg_q  <= seq_cfg_t'(cfg_wdata);
            if (vr_wr && !busy)  vrange <= vr_wdata;
        end
    end

    adc_seq_trig trig_i (
        .clk(clk), .rst(rst), .src(cfg_q.src), .sw_start(sw_start),
        .tmr_uf(tmr_uf), .ext_trig_n(ext_trig_n), .fire(fire)
    );

    adc_seq_fsm fsm_i (
        .clk(clk), .rst(rst), .arm(arm), .fire(fire), .sw_stop(sw_stop),
        .smp_ce(smp_ce), .repeat_en(cfg_q.repeat_en), .wcode(cfg_q.wcode),
        .conv_done(conv_done), .conv_req(conv_req), .busy(busy), .capture(capture)
    );

    adc_seq_result res_i (
        .clk(clk), .rst(rst), .capture(capture), .conv_data(conv_data),
        .align_left(cfg_q.align_left), .res_read(res_read), .result(result),
        .res_ready(res_ready), .overrun(overrun)
    );

    assert_vr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(vrange));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, vr_wr = 0, arm = 0, sw_start = 0, sw_stop = 0, tmr_uf = 0;
    logic ext_trig_n = 1, smp_ce = 0, conv_done = 0, res_read = 0;
    logic [6:0]  cfg_wdata = '0;
    logic [1:0]  vr_wdata = '0;
    logic [11:0] conv_data = '0;
    logic        conv_req, busy, res_ready, overrun;
    logic [15:0] result;
    logic [1:0]  vrange;

    always #5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .vr_wr(vr_wr),
        .vr_wdata(vr_wdata), .arm(arm), .sw_start(sw_start), .sw_stop(sw_stop),
        .tmr_uf(tmr_uf), .ext_trig_n(ext_trig_n), .smp_ce(smp_ce), .conv_done(conv_done),
        .conv_data(conv_data), .res_read(res_read), .conv_req(conv_req), .busy(busy),
        .result(result), .res_ready(res_ready), .overrun(overrun), .vrange(vrange)
    );

    int checks = 0, errs = 0;
    int ce_div = 1, ce_ph = 0;
    bit ce_on = 0;
    bit model_on = 0;
    int cycles = 0;

    // behavioural reference
    int m_phase = 0, m_cnt = 0;
    bit m_stop = 0, m_rdy = 0, m_unread = 0, m_ovr = 0;
    int m_data = 0, m_vr = 0;
    int m_align = 0, m_rep = 0, m_src = 0, m_code = 0;
    bit p1 = 1, p2 = 1, p3 = 1;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_stop = 0; m_rdy = 0; m_unread = 0; m_ovr = 0;
            m_data = 0; m_vr = 0; m_align = 0; m_rep = 0; m_src = 0; m_code = 0;
            p1 = 1; p2 = 1; p3 = 1;
        end else begin
            bit go, cap, was_busy;
            int nxt;
            go = (m_src == 0 && sw_start) || (m_src == 2 && tmr_uf) || (m_src == 3 && p3 && !p2);
            cap = (m_phase == 4) && conv_done;
            was_busy = (m_phase >= 2);
            nxt = m_phase;
            if (m_phase == 0) begin
                if (arm) nxt = 1;
            end else if (m_phase == 1) begin
                if (sw_stop) nxt = 0;
                else if (go) begin nxt = 2; m_cnt = 0; end
            end else if (m_phase == 2) begin
                if (smp_ce) begin
                    if (m_cnt + 1 == m_code + 4) nxt = 3;
                    else m_cnt++;
                end
            end else if (m_phase == 3) begin
                nxt = 4;
            end else if (conv_done) begin
                if (m_rep != 0 && !m_stop && !sw_stop) begin nxt = 2; m_cnt = 0; end
                else nxt = 0;
            end
            if (nxt == 0) m_stop = 0;
            else if (sw_stop && was_busy) m_stop = 1;
            m_phase = nxt;
            m_rdy = cap;
            if (cap && m_unread && !res_read) m_ovr = 1;
            else if (res_read) m_ovr = 0;
            if (cap) m_unread = 1;
            else if (res_read) m_unread = 0;
            if (cap) m_data = int'(conv_data);
            if (cfg_wr) begin
                m_align = cfg_wdata[0]; m_rep = cfg_wdata[1];
                m_src = cfg_wdata[3:2]; m_code = cfg_wdata[6:4];
            end
            if (vr_wr && !was_busy) m_vr = vr_wdata;
            p3 = p2; p2 = p1; p1 = ext_trig_n;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            chk(busy, m_phase >= 2, "R8 busy");
            chk(conv_req, m_phase == 3, "R4 conv_req");
            chk(result, m_align != 0 ? (m_data << 4) : m_data, "R2 result");
            chk(res_ready, m_rdy, "R10 res_ready");
            chk(overrun, m_ovr, "R11 overrun");
            chk(vrange, m_vr, "R9 vrange");
        end
        if (ce_on) begin
            smp_ce <= (ce_ph == 0);
            ce_ph = (ce_ph + 1) % ce_div;
        end else smp_ce <= 0;
        if (cycles > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int align, input int rep, input int src, input int code);
        cfg_wdata = 7'((code << 4) | (src << 2) | (rep << 1) | align);
        cfg_wr = 1; tick(); cfg_wr = 0;
    endtask

    task automatic pulse_arm();   arm = 1; tick(); arm = 0; endtask
    task automatic pulse_start(); sw_start = 1; tick(); sw_start = 0; endtask
    task automatic pulse_stop();  sw_stop = 1; tick(); sw_stop = 0; endtask
    task automatic pulse_read();  res_read = 1; tick(); res_read = 0; endtask

    task automatic wait_req();
        for (int i = 0; i < 300 && conv_req !== 1'b1; i++) tick();
    endtask

    // after conv_req is seen: capture one value
    task automatic finish_conv(input logic [11:0] d);
        tick();
        conv_data = d; conv_done = 1; tick(); conv_done = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        model_on = 1;
        tick();
        chk(busy, 0, "R1 busy"); chk(result, 0, "R1 result"); chk(vrange, 0, "R1 vrange");
        chk(conv_req, 0, "R1 conv_req"); chk(res_ready, 0, "R1 res_ready");

        // reset config: soft start, single, window 4, right aligned
        ce_on = 1; ce_div = 1;
        pulse_arm();
        chk(busy, 0, "R8 armed not busy");
        pulse_start();
        chk(busy, 1, "R3 soft start accepted");
        wait_req();
        conv_done = 1; tick(); conv_done = 0;   // done during request cycle: ignored
        chk(res_ready, 0, "R12 early done ignored");
        tick();
        conv_data = 12'hABC; conv_done = 1; tick(); conv_done = 0;
        chk(result, 16'h0ABC, "R2 right aligned");
        tick();
        chk(busy, 0, "R5 single returns idle");
        pulse_start();
        chk(busy, 0, "R5 start needs arm");
        write_cfg(1, 0, 0, 0);
        chk(result, 16'hABC0, "R2 live left align");
        pulse_read();

        // code 1: nothing starts
        write_cfg(0, 0, 1, 2);
        pulse_arm();
        pulse_start(); tmr_uf = 1; tick(); tmr_uf = 0;
        ext_trig_n = 0; tick(5); ext_trig_n = 1; tick(4);
        chk(busy, 0, "R3 code1 never starts");
        pulse_stop();

        // timer start, window 11, slow enable
        write_cfg(0, 0, 2, 7);
        ce_div = 3;
        vr_wdata = 2'd2; vr_wr = 1; tick(); vr_wr = 0;
        chk(vrange, 2, "R9 idle write taken");
        pulse_arm();
        pulse_start();
        chk(busy, 0, "R3 soft start ignored for timer");
        tmr_uf = 1; tick(); tmr_uf = 0;
        chk(busy, 1, "R3 timer start");
        wait_req();
        finish_conv(12'h123);
        tick();

        // pin start, window 6
        write_cfg(1, 0, 3, 2);
        ce_div = 1;
        pulse_arm();
        ext_trig_n = 0;
        tick(2);
        chk(busy, 0, "R7 not yet accepted");
        tick();
        chk(busy, 1, "R7 accepted after sync");
        wait_req();
        finish_conv(12'hFED);
        tick(3);
        chk(busy, 0, "R7 held low no retrigger");
        ext_trig_n = 1; tick(3);

        // repeat mode with overrun, busy range write, stop
        write_cfg(0, 1, 0, 1);
        ce_div = 2;
        pulse_arm();
        pulse_start();
        vr_wdata = 2'd1; vr_wr = 1; tick(); vr_wr = 0;
        chk(vrange, 2, "R9 busy write ignored");
        wait_req(); finish_conv(12'h111);
        tick();
        chk(busy, 1, "R6 repeat keeps running");
        wait_req(); finish_conv(12'h222);
        chk(overrun, 1, "R11 overrun set");
        pulse_stop();
        wait_req(); finish_conv(12'h333);
        tick();
        chk(busy, 0, "R6 stop after capture");
        chk(result, 16'h0333, "R6 last value kept");
        pulse_read();
        chk(overrun, 0, "R11 read clears");

        // stop while armed disarms
        pulse_arm();
        pulse_stop();
        pulse_start();
        chk(busy, 0, "R6 stop disarms");
        tick(4);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule